// File: doc/BRIEF.md
# Port Pin Function Multiplexer

This block connects the twelve pads of one I/O port to a set of on-chip peripherals. Each pad has its own mode register on a simple register bus. The register holds a five-bit function code and a two-bit pull/direction code. From these settings the block drives each pad's output value, output enable, pull-up and pull-down controls, and analog-switch select. The source can be a peripheral output, an open-drain peripheral, a diagnostic line or a GPIO data bit.

In the other direction the block feeds the pad levels to the peripheral inputs. When several pads claim the same input function, the pad with the lowest index wins. A peripheral input that no pad claims is held at its idle level. Analog selection is allowed only on a fixed subset of pads. The four diagnostic lines appear on pads 0 to 3 and are mirrored onto pads 8 to 11. A register write takes effect at the next clock edge. All pad controls are combinational from the stored configuration.

Top module: `port_pinmux`

## Requirements
- R1: Each pad has a 16-bit mode register at bus address equal to the pad index. It stores the function code in bits 4:0 and the pull/direction code in bits 9:8. All other bits read 0. Any write is kept only in those bits, so writing 0xFFFF reads back 0x031F. Addresses 12 to 15 read 0, and a write to them changes nothing.
- R2: After reset every mode register reads 0x0200. Every pad is then an undriven GPIO input with the pull-down on and the pull-up off.
- R3: Function code 0 is GPIO. Pull code 00 gives an input with no pull, 01 an input with pull-up, and 10 an input with pull-down. Pull code 11 makes the pad an output driving `gpio_out` of that pad, with both pulls off. Pull-up and pull-down are never both on.
- R4: These codes are output functions: 2 UART1 TX, 4 UART2 TX, 5 system clock, 6 low-power clock, 11/12/13 PWM5/6/7, 16/17 PWM0/1, 20 UART1 RTS, 23/24/25 PWM2/3/4, 27 SPI DO, 28 SPI CLK, 29 SPI CS0, 30 SPI CS1. An output function sets the output enable, drives the selected signal, and turns both pulls off, whatever the pull code holds.
- R5: These codes are input functions: 1 UART1 RX, 3 UART2 RX, 19 UART1 CTS, 26 SPI DI. The pad is not driven. Pull codes 01 and 10 enable the pull-up or pull-down, and 00 or 11 enable no pull. The peripheral input takes the level of the lowest-index pad that selects its code.
- R6: A peripheral input that no pad selects holds its idle level: 1 for UART1 RX, UART2 RX and UART1 CTS, and 0 for SPI DI, I2C SCL and I2C SDA.
- R7: Codes 9 (I2C SCL) and 10 (I2C SDA) are open-drain. The pad output is 0, and its enable follows that line's drive-low request. Pulls follow the pull code as for inputs. The line's input follows the lowest-index selecting pad, as in R5.
- R8: Code 15 (analog) asserts `adc_sel` only on pads 1, 2, 6 and 7. On those pads it disables the output and both pulls, whatever the pull code holds. `adc_sel` is never high on any other pad.
- R9: Code 18 (diagnostic) drives `diag[i]` on pad i for i in 0..3, and `diag[i-8]` on pad i for i in 8..11, with output enable on and pulls off. On pads 4 to 7 it is inert as in R10.
- R10: Reserved codes (7, 8, 14, 21, 22, 31) leave the pad inert: output enable, output, both pulls and `adc_sel` are all 0. So do code 15 off the analog pads and code 18 on pads 4 to 7.
- R11: `pad_out` is 0 on every pad whose `pad_oe` is 0.
- R12: A write changes the pad controls and the read data only after the clock edge that captures it. Up to that edge the old configuration still drives the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (pad index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| gpio_out | input | 12 | GPIO output data, one bit per pad |
| gpio_in | output | 12 | Pad input levels seen by GPIO |
| uart1_tx | input | 1 | UART1 transmit data |
| uart2_tx | input | 1 | UART2 transmit data |
| sys_clk_out | input | 1 | System clock to be output |
| lp_clk_out | input | 1 | Low-power clock to be output |
| pwm | input | 8 | PWM channel outputs 0..7 |
| uart1_rts | input | 1 | UART1 request-to-send |
| spi_do | input | 1 | SPI data out |
| spi_clk | input | 1 | SPI clock |
| spi_cs0 | input | 1 | SPI chip select 0 |
| spi_cs1 | input | 1 | SPI chip select 1 |
| scl_drive_low | input | 1 | I2C clock line pull-low request |
| sda_drive_low | input | 1 | I2C data line pull-low request |
| diag | input | 4 | Diagnostic lines |
| uart1_rx | output | 1 | UART1 receive data to peripheral |
| uart2_rx | output | 1 | UART2 receive data to peripheral |
| uart1_cts | output | 1 | UART1 clear-to-send to peripheral |
| spi_di | output | 1 | SPI data in to peripheral |
| scl_in | output | 1 | I2C clock line level to peripheral |
| sda_in | output | 1 | I2C data line level to peripheral |
| pad_in | input | 12 | Pad input levels |
| pad_out | output | 12 | Pad output values |
| pad_oe | output | 12 | Pad output enables |
| pad_pu | output | 12 | Pad pull-up enables |
| pad_pd | output | 12 | Pad pull-down enables |
| adc_sel | output | 12 | Pad analog switch selects |

## Verification
The bench sets the same input function on two and then three pads with opposite levels. A design that let the highest or the most recent pad win would show the wrong SPI DI level. It writes the analog and diagnostic codes to pads that do not allow them; a design that skipped the pad limits would raise `adc_sel` or drive pad 5. It sets output and analog functions with pull bits that would otherwise enable a pull, which exposes any leak of the pull code into those modes. It also checks the pads in the cycle before and after a write edge, reads back unused bits and out-of-range addresses, and checks idle levels of unclaimed inputs. A design that wrote early, kept stray bits or aliased the address would fail one of these.

// File: rtl/port_pinmux_pkg.sv
package port_pinmux_pkg;

  localparam int MODE_W   = 16;
  localparam int FUNC_W   = 5;
  localparam int PULL_W   = 2;
  localparam int PULL_LSB = 8;

  localparam logic [MODE_W-1:0] MODE_RESET = 16'h0200;
  localparam logic [MODE_W-1:0] MODE_MASK  = 16'h031F;

  // pull / direction codes
  localparam logic [PULL_W-1:0] PULL_NONE = 2'b00;
  localparam logic [PULL_W-1:0] PULL_UP   = 2'b01;
  localparam logic [PULL_W-1:0] PULL_DOWN = 2'b10;
  localparam logic [PULL_W-1:0] PULL_OUT  = 2'b11;

  // function codes
  localparam logic [FUNC_W-1:0] FN_GPIO    = 5'd0;
  localparam logic [FUNC_W-1:0] FN_U1_RX   = 5'd1;
  localparam logic [FUNC_W-1:0] FN_U1_TX   = 5'd2;
  localparam logic [FUNC_W-1:0] FN_U2_RX   = 5'd3;
  localparam logic [FUNC_W-1:0] FN_U2_TX   = 5'd4;
  localparam logic [FUNC_W-1:0] FN_SYSCLK  = 5'd5;
  localparam logic [FUNC_W-1:0] FN_LPCLK   = 5'd6;
  localparam logic [FUNC_W-1:0] FN_SCL     = 5'd9;
  localparam logic [FUNC_W-1:0] FN_SDA     = 5'd10;
  localparam logic [FUNC_W-1:0] FN_PWM5    = 5'd11;
  localparam logic [FUNC_W-1:0] FN_PWM6    = 5'd12;
  localparam logic [FUNC_W-1:0] FN_PWM7    = 5'd13;
  localparam logic [FUNC_W-1:0] FN_ANALOG  = 5'd15;
  localparam logic [FUNC_W-1:0] FN_PWM0    = 5'd16;
  localparam logic [FUNC_W-1:0] FN_PWM1    = 5'd17;
  localparam logic [FUNC_W-1:0] FN_DIAG    = 5'd18;
  localparam logic [FUNC_W-1:0] FN_U1_CTS  = 5'd19;
  localparam logic [FUNC_W-1:0] FN_U1_RTS  = 5'd20;
  localparam logic [FUNC_W-1:0] FN_PWM2    = 5'd23;
  localparam logic [FUNC_W-1:0] FN_PWM3    = 5'd24;
  localparam logic [FUNC_W-1:0] FN_PWM4    = 5'd25;
  localparam logic [FUNC_W-1:0] FN_SPI_DI  = 5'd26;
  localparam logic [FUNC_W-1:0] FN_SPI_DO  = 5'd27;
  localparam logic [FUNC_W-1:0] FN_SPI_CLK = 5'd28;
  localparam logic [FUNC_W-1:0] FN_SPI_CS0 = 5'd29;
  localparam logic [FUNC_W-1:0] FN_SPI_CS1 = 5'd30;

  typedef struct packed {
    logic [PULL_W-1:0] pull;
    logic [FUNC_W-1:0] func;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{pull: MODE_RESET[PULL_LSB +: PULL_W],
                                     func: MODE_RESET[FUNC_W-1:0]};

  // peripheral signals heading for the pads
  typedef struct packed {
    logic       u1_tx;
    logic       u2_tx;
    logic       sys_clk;
    logic       lp_clk;
    logic       u1_rts;
    logic       spi_do;
    logic       spi_clk;
    logic       spi_cs0;
    logic       spi_cs1;
    logic       scl_low;
    logic       sda_low;
    logic [7:0] pwm;
  } periph_src_t;

  // peripheral inputs fed from the pads
  localparam int IN_U1_RX  = 0;
  localparam int IN_U2_RX  = 1;
  localparam int IN_U1_CTS = 2;
  localparam int IN_SPI_DI = 3;
  localparam int IN_SCL    = 4;
  localparam int IN_SDA    = 5;
  localparam int NUM_IN    = 6;

  localparam logic [NUM_IN-1:0] IN_IDLE = 6'b000111;

  function automatic logic [FUNC_W-1:0] in_code(input int k);
    case (k)
      IN_U1_RX:  in_code = FN_U1_RX;
      IN_U2_RX:  in_code = FN_U2_RX;
      IN_U1_CTS: in_code = FN_U1_CTS;
      IN_SPI_DI: in_code = FN_SPI_DI;
      IN_SCL:    in_code = FN_SCL;
      default:   in_code = FN_SDA;
    endcase
  endfunction

endpackage

// File: rtl/port_pinmux_regs.sv
module port_pinmux_regs
  import port_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int ADDR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [MODE_W-1:0]       bus_wdata,
  output logic [MODE_W-1:0]       bus_rdata,
  output pin_cfg_t [NUM_PINS-1:0] cfg,
  output logic                    rst_sync_n
);

  logic [1:0] rst_pipe_q;
  pin_cfg_t [NUM_PINS-1:0] mode_q, mode_d;
  logic [NUM_PINS-1:0]     mode_en;
  pin_cfg_t                wr_cfg;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_cfg.pull = bus_wdata[PULL_LSB +: PULL_W];
  assign wr_cfg.func = bus_wdata[FUNC_W-1:0];

  always_comb begin
    mode_d  = mode_q;
    mode_en = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_we && (bus_addr == ADDR_W'(p))) begin
        mode_en[p] = 1'b1;
        mode_d[p]  = wr_cfg;
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)     mode_q[p] <= CFG_RESET;
      else if (mode_en[p]) mode_q[p] <= mode_d[p];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == ADDR_W'(p)) begin
        bus_rdata[PULL_LSB +: PULL_W] = mode_q[p].pull;
        bus_rdata[FUNC_W-1:0]         = mode_q[p].func;
      end
    end
  end

  assign cfg = mode_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[MODE_W-1:PULL_LSB+PULL_W],
                          bus_wdata[PULL_LSB-1:FUNC_W]};

endmodule

// File: rtl/port_pinmux_pad_ctrl.sv
module port_pinmux_pad_ctrl
  import port_pinmux_pkg::*;
#(
  parameter bit ANALOG_OK = 1'b0,
  parameter bit DIAG_OK   = 1'b0
) (
  input  pin_cfg_t    cfg,
  input  periph_src_t src,
  input  logic        gpio_bit,
  input  logic        diag_bit,
  output logic        out,
  output logic        oe,
  output logic        pu,
  output logic        pd,
  output logic        adc
);

  logic in_pu, in_pd;
  logic drive, drive_val;

  assign in_pu = (cfg.pull == PULL_UP);
  assign in_pd = (cfg.pull == PULL_DOWN);

  // push-pull sources
  always_comb begin
    drive     = 1'b1;
    drive_val = 1'b0;
    case (cfg.func)
      FN_GPIO: begin
        drive     = (cfg.pull == PULL_OUT);
        drive_val = gpio_bit;
      end
      FN_U1_TX:   drive_val = src.u1_tx;
      FN_U2_TX:   drive_val = src.u2_tx;
      FN_SYSCLK:  drive_val = src.sys_clk;
      FN_LPCLK:   drive_val = src.lp_clk;
      FN_PWM0:    drive_val = src.pwm[0];
      FN_PWM1:    drive_val = src.pwm[1];
      FN_PWM2:    drive_val = src.pwm[2];
      FN_PWM3:    drive_val = src.pwm[3];
      FN_PWM4:    drive_val = src.pwm[4];
      FN_PWM5:    drive_val = src.pwm[5];
      FN_PWM6:    drive_val = src.pwm[6];
      FN_PWM7:    drive_val = src.pwm[7];
      FN_U1_RTS:  drive_val = src.u1_rts;
      FN_SPI_DO:  drive_val = src.spi_do;
      FN_SPI_CLK: drive_val = src.spi_clk;
      FN_SPI_CS0: drive_val = src.spi_cs0;
      FN_SPI_CS1: drive_val = src.spi_cs1;
      FN_DIAG: begin
        drive     = DIAG_OK;
        drive_val = diag_bit;
      end
      default:    drive = 1'b0;
    endcase
  end

  // pad control composition
  always_comb begin
    out = 1'b0;
    oe  = 1'b0;
    pu  = 1'b0;
    pd  = 1'b0;
    adc = 1'b0;
    if (drive) begin
      oe  = 1'b1;
      out = drive_val;
    end else begin
      case (cfg.func)
        FN_GPIO, FN_U1_RX, FN_U2_RX, FN_U1_CTS, FN_SPI_DI: begin
          pu = in_pu;
          pd = in_pd;
        end
        FN_SCL: begin
          pu = in_pu;
          pd = in_pd;
          oe = src.scl_low;
        end
        FN_SDA: begin
          pu = in_pu;
          pd = in_pd;
          oe = src.sda_low;
        end
        FN_ANALOG: adc = ANALOG_OK;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/port_pinmux_in_route.sv
module port_pinmux_in_route
  import port_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  pin_cfg_t [NUM_PINS-1:0] cfg,
  input  logic [NUM_PINS-1:0]     pad_in,
  output logic [NUM_IN-1:0]       periph_in
);

  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    localparam logic [FUNC_W-1:0] CODE = in_code(k);
    logic [NUM_PINS-1:0] claim;

    always_comb begin
      for (int p = 0; p < NUM_PINS; p++) claim[p] = (cfg[p].func == CODE);
    end

    // scan from the top so the lowest claiming pad is applied last
    always_comb begin
      periph_in[k] = IN_IDLE[k];
      for (int p = NUM_PINS-1; p >= 0; p--) begin
        if (claim[p]) periph_in[k] = pad_in[p];
      end
    end
  end

endmodule

// File: rtl/port_pinmux.sv
module port_pinmux
  import port_pinmux_pkg::*;
#(
  parameter int                NUM_PINS     = 12,
  parameter int                ADDR_W       = 4,
  parameter int                DIAG_W       = 4,
  parameter int                DIAG_MIRROR  = 8,
  parameter logic [NUM_PINS-1:0] ANALOG_MASK = 12'h0C6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_in,
  input  logic                uart1_tx,
  input  logic                uart2_tx,
  input  logic                sys_clk_out,
  input  logic                lp_clk_out,
  input  logic [7:0]          pwm,
  input  logic                uart1_rts,
  input  logic                spi_do,
  input  logic                spi_clk,
  input  logic                spi_cs0,
  input  logic                spi_cs1,
  input  logic                scl_drive_low,
  input  logic                sda_drive_low,
  input  logic [DIAG_W-1:0]   diag,
  output logic                uart1_rx,
  output logic                uart2_rx,
  output logic                uart1_cts,
  output logic                spi_di,
  output logic                scl_in,
  output logic                sda_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_pd,
  output logic [NUM_PINS-1:0] adc_sel
);

  pin_cfg_t [NUM_PINS-1:0] cfg;
  periph_src_t             src;
  logic [NUM_IN-1:0]       periph_in;
  logic                    rst_sync_n;

  port_pinmux_regs #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .rst_sync_n(rst_sync_n)
  );

  assign src.u1_tx   = uart1_tx;
  assign src.u2_tx   = uart2_tx;
  assign src.sys_clk = sys_clk_out;
  assign src.lp_clk  = lp_clk_out;
  assign src.u1_rts  = uart1_rts;
  assign src.spi_do  = spi_do;
  assign src.spi_clk = spi_clk;
  assign src.spi_cs0 = spi_cs0;
  assign src.spi_cs1 = spi_cs1;
  assign src.scl_low = scl_drive_low;
  assign src.sda_low = sda_drive_low;
  assign src.pwm     = pwm;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit IS_DIAG_LO = (p < DIAG_W);
    localparam bit IS_DIAG_HI = (p >= DIAG_MIRROR) && (p < DIAG_MIRROR + DIAG_W);
    logic diag_bit;

    if (IS_DIAG_LO) begin : g_dlo
      assign diag_bit = diag[p];
    end else if (IS_DIAG_HI) begin : g_dhi
      assign diag_bit = diag[p-DIAG_MIRROR];
    end else begin : g_dnone
      assign diag_bit = 1'b0;
    end

    port_pinmux_pad_ctrl #(
      .ANALOG_OK(ANALOG_MASK[p]),
      .DIAG_OK  (IS_DIAG_LO || IS_DIAG_HI)
    ) u_pad (
      .cfg     (cfg[p]),
      .src     (src),
      .gpio_bit(gpio_out[p]),
      .diag_bit(diag_bit),
      .out     (pad_out[p]),
      .oe      (pad_oe[p]),
      .pu      (pad_pu[p]),
      .pd      (pad_pd[p]),
      .adc     (adc_sel[p])
    );
  end

  port_pinmux_in_route #(
    .NUM_PINS(NUM_PINS)
  ) u_in_route (
    .cfg      (cfg),
    .pad_in   (pad_in),
    .periph_in(periph_in)
  );

  assign gpio_in   = pad_in;
  assign uart1_rx  = periph_in[IN_U1_RX];
  assign uart2_rx  = periph_in[IN_U2_RX];
  assign uart1_cts = periph_in[IN_U1_CTS];
  assign spi_di    = periph_in[IN_SPI_DI];
  assign scl_in    = periph_in[IN_SCL];
  assign sda_in    = periph_in[IN_SDA];

endmodule

// File: rtl/port_pinmux_checker.sv
module port_pinmux_checker
  import port_pinmux_pkg::*;
#(
  parameter int                  NUM_PINS    = 12,
  parameter int                  ADDR_W      = 4,
  parameter logic [NUM_PINS-1:0] ANALOG_MASK = 12'h0C6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [15:0]             bus_wdata,
  input logic [15:0]             bus_rdata,
  input pin_cfg_t [NUM_PINS-1:0] cfg,
  input logic [NUM_PINS-1:0]     pad_out,
  input logic [NUM_PINS-1:0]     pad_oe,
  input logic [NUM_PINS-1:0]     pad_pu,
  input logic [NUM_PINS-1:0]     pad_pd,
  input logic [NUM_PINS-1:0]     adc_sel,
  input logic                    uart1_rx
);

  logic [NUM_PINS-1:0] tx_pins, rx_claim;
  logic                addr_ok;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      tx_pins[p]  = (cfg[p].func == FN_U1_TX);
      rx_claim[p] = (cfg[p].func == FN_U1_RX);
    end
  end

  assign addr_ok = ({1'b0, bus_addr} < (ADDR_W+1)'(NUM_PINS));

  p_rsvd_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~MODE_MASK) == 16'h0);

  p_pulls_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  p_tx_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_pins & ~pad_oe) == '0) && ((tx_pins & (pad_pu | pad_pd)) == '0));

  p_rx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_claim == '0) |-> uart1_rx);

  p_analog_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel & ~ANALOG_MASK) == '0);

  p_analog_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel & (pad_oe | pad_pu | pad_pd)) == '0);

  p_released_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && addr_ok) |=>
      ((bus_addr != $past(bus_addr)) || (bus_rdata == ($past(bus_wdata) & MODE_MASK))));

endmodule

bind port_pinmux port_pinmux_checker #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .ANALOG_MASK(ANALOG_MASK)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cfg      (cfg),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd),
  .adc_sel  (adc_sel),
  .uart1_rx (uart1_rx)
);

// File: tb/port_pinmux_bench.sv
`timescale 1ns/1ps
module port_pinmux_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [11:0] gpio_out = '0, gpio_in;
  logic        uart1_tx = 0, uart2_tx = 0, sys_clk_out = 0, lp_clk_out = 0;
  logic [7:0]  pwm = '0;
  logic        uart1_rts = 0, spi_do = 0, spi_clk = 0, spi_cs0 = 0, spi_cs1 = 0;
  logic        scl_drive_low = 0, sda_drive_low = 0;
  logic [3:0]  diag = '0;
  logic        uart1_rx, uart2_rx, uart1_cts, spi_di, scl_in, sda_in;
  logic [11:0] pad_in = '0;
  logic [11:0] pad_out, pad_oe, pad_pu, pad_pd, adc_sel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  port_pinmux u_port_pinmux (.*);

  // {pin[3:0], mode word[15:0], source level, expected {adc,pd,pu,oe,out}}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {4'd0,  16'h0300, 1'b1, 5'b00011},
    {4'd0,  16'h0300, 1'b0, 5'b00010},
    {4'd3,  16'h0100, 1'b1, 5'b00100},
    {4'd4,  16'h0000, 1'b1, 5'b00000},
    {4'd5,  16'h0202, 1'b1, 5'b00011},
    {4'd6,  16'h030F, 1'b1, 5'b10000},
    {4'd5,  16'h020F, 1'b1, 5'b00000},
    {4'd7,  16'h0107, 1'b1, 5'b00000},
    {4'd2,  16'h0101, 1'b1, 5'b00100},
    {4'd9,  16'h0009, 1'b1, 5'b00010},
    {4'd10, 16'h020A, 1'b0, 5'b01000},
    {4'd11, 16'h0312, 1'b1, 5'b00011},
    {4'd5,  16'h0312, 1'b1, 5'b00000},
    {4'd8,  16'h001B, 1'b1, 5'b00011},
    {4'd1,  16'h0010, 1'b1, 5'b00011},
    {4'd3,  16'h0313, 1'b1, 5'b00000}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 3: vec_tag = "R3";
      4, 13, 14:  vec_tag = "R4";
      5, 6:       vec_tag = "R8";
      7:          vec_tag = "R10";
      8, 15:      vec_tag = "R5";
      9, 10:      vec_tag = "R7";
      default:    vec_tag = "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_mode(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_sources(input logic v);
    gpio_out = {12{v}};
    uart1_tx = v; uart2_tx = v; sys_clk_out = v; lp_clk_out = v;
    pwm = {8{v}}; uart1_rts = v; spi_do = v; spi_clk = v; spi_cs0 = v; spi_cs1 = v;
    scl_drive_low = v; sda_drive_low = v; diag = {4{v}};
  endtask

  function automatic logic [4:0] pin_view(input int p);
    pin_view = {adc_sel[p], pad_pd[p], pad_pu[p], pad_oe[p], pad_out[p]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset state
    for (int p = 0; p < 12; p++) begin
      read_mode(4'(p), rd);
      chk("R2 reset value", rd, 16'h0200);
    end
    chk("R2 reset pd", pad_pd, 12'hFFF);
    chk("R2 reset pu/oe/out/adc", {pad_pu, pad_oe, pad_out, adc_sel}, 48'h0);
    // R6: idle levels with nothing claimed
    chk("R6 idle", {uart1_rx, uart2_rx, uart1_cts, spi_di, scl_in, sda_in}, 6'b111000);

    // R12: old config holds until the capturing edge
    set_sources(1'b1);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 16'h0300;
    #1;
    chk("R12 before edge oe", pad_oe[0], 1'b0);
    @(negedge clk);
    bus_we = 1'b0;
    chk("R12 after edge oe/out", {pad_oe[0], pad_out[0]}, 2'b11);

    // table walk
    for (int i = 0; i < NV; i++) begin
      set_sources(VEC[i][5]);
      write_mode(VEC[i][25:22], VEC[i][21:6]);
      chk(vec_tag(i), pin_view(int'(VEC[i][25:22])), VEC[i][4:0]);
    end

    // R1: stored bits and out-of-range addresses
    write_mode(4'd4, 16'hFFFF);
    read_mode(4'd4, rd);
    chk("R1 masked readback", rd, 16'h031F);
    write_mode(4'd12, 16'h0000);
    write_mode(4'd15, 16'h0000);
    read_mode(4'd12, rd);
    chk("R1 addr 12 reads zero", rd, 16'h0000);
    read_mode(4'd4, rd);
    chk("R1 pad 4 untouched", rd, 16'h031F);
    read_mode(4'd0, rd);
    chk("R1 pad 0 untouched", rd, 16'h0300);

    // R11: GPIO input with data high stays low
    write_mode(4'd0, 16'h0000);
    set_sources(1'b1);
    #1;
    chk("R11 released out low", {pad_oe[0], pad_out[0]}, 2'b00);

    // R5: lowest index wins on SPI DI
    write_mode(4'd4, 16'h001A);
    write_mode(4'd9, 16'h001A);
    pad_in = 12'b0010_0000_0000;
    #1;
    chk("R5 pad4 beats pad9 (0)", spi_di, 1'b0);
    pad_in = 12'b0000_0001_0000;
    #1;
    chk("R5 pad4 beats pad9 (1)", spi_di, 1'b1);
    write_mode(4'd2, 16'h001A);
    pad_in = 12'b0000_0000_0100;
    #1;
    chk("R5 pad2 takes over", spi_di, 1'b1);
    // pad 2 left code 1: UART1 RX unclaimed again
    chk("R6 uart1 rx idle", uart1_rx, 1'b1);
    // pad 3 holds code 19
    pad_in = 12'b0000_0000_0000;
    #1;
    chk("R5 cts follows pad3", uart1_cts, 1'b0);
    // R7: pad 10 holds SDA
    pad_in = 12'b0100_0000_0000;
    #1;
    chk("R7 sda follows pad10", sda_in, 1'b1);
    chk("R6 scl idle after pad9 left", scl_in, 1'b0);

    // R9: diagnostic mirroring
    write_mode(4'd0, 16'h0012);
    write_mode(4'd8, 16'h0012);
    set_sources(1'b0);
    diag = 4'b0001;
    #1;
    chk("R9 diag0 on pads 0 and 8", {pad_out[8], pad_out[0], pad_oe[8], pad_oe[0]}, 4'b1111);
    diag = 4'b1110;
    #1;
    chk("R9 diag0 low, diag3 on pad11", {pad_out[11], pad_out[8], pad_out[0]}, 3'b100);

    // R4: PWM channel and clock selection
    write_mode(4'd1, 16'h0010);
    write_mode(4'd6, 16'h0019);
    write_mode(4'd7, 16'h0205);
    pwm = 8'b0001_0000;
    #1;
    chk("R4 pwm4 on pad6 only", {pad_out[6], pad_out[1]}, 2'b10);
    sys_clk_out = 1'b1; pwm = 8'h00;
    #1;
    chk("R4 sysclk on pad7", {pad_oe[7], pad_out[7], pad_pd[7]}, 3'b110);

    // R8/R10: analog on pad 2 allowed, reserved on pad 7
    write_mode(4'd2, 16'h010F);
    write_mode(4'd7, 16'h0316);
    #1;
    chk("R8 analog pad2", pin_view(2), 5'b10000);
    chk("R10 reserved 22 pad7", pin_view(7), 5'b00000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule